// File: doc/BRIEF.md
# In-Order Retirement Queue with Speculation and Precise Faults

This block keeps an out-of-order core's instructions in program order between issue and retirement. Each issued instruction gets a slot in a circular queue. Its slot index is the tag that functional units later return with a result. Results may arrive in any order. Retirement always happens from the oldest end of the queue, so the architectural state changes in program order.

Every slot stores a destination register number, a result, a completion mark and a fault mark. It also stores a speculation mark together with the identifier of the branch it depends on. When a branch resolves on its predicted path, the speculation marks tied to it are cleared and those slots may retire. When a branch mispredicts, every slot younger than the branch is dropped at once. A fault is only noted in its slot when it is reported. The fault is acted on when that slot reaches the oldest position: the faulting slot and all younger slots are then discarded without retiring, at a bounded rate, and a fault request carrying the slot index is raised.

Top module: `retire_queue`

## Requirements
- R1: After reset nothing retires, no fault is raised, allocation is not stalled and the first slot handed out is index 0.
- R2: Requesting allocation lanes receive consecutive slot indices in lane order (lane 0 first), continuing from the previous allocation and wrapping modulo DEPTH.
- R3: When the number of requesting lanes exceeds the free slot count, alloc_stall_o is high and no slot is taken that cycle.
- R4: Completions may arrive in any order; retirement stops at the first oldest-end slot that is not complete, and a newly allocated slot is never complete.
- R5: At most RET_W (2) slots retire per cycle, in program order, with lane 0 carrying the oldest slot; ret_valid_o is always a contiguous run starting at lane 0.
- R6: A speculative slot does not retire until a correct-path resolution with its own branch identifier clears its mark; a resolution with another identifier has no effect.
- R7: On a mispredict, all slots younger than the indicated branch slot are dropped in that cycle: they never retire, and the next allocation gets the slot right after the branch. Allocation is stalled in the mispredict cycle.
- R8: A complete, non-speculative faulting slot at the oldest position raises exc_valid_o for exactly one cycle with exc_tag_o equal to its index. It does not retire, and allocation is stalled in that cycle.
- R9: After a fault, the remaining younger slots are removed at most RET_W per cycle without retiring. Allocation stays stalled until the queue is empty and then resumes at the slot after the last one that was dropped.
- R10: The queue holds exactly DEPTH slots. Full and empty are told apart, so a full queue refuses even one request, and indices wrap correctly after the queue fills.
- R11: A faulting slot in retire lane 1 does not retire; the older slot in lane 0 still retires in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alloc_req_i | input | ALLOC_W | Per-lane allocation request |
| alloc_dest_i | input | ALLOC_W x DEST_W | Destination register per lane |
| alloc_spec_i | input | ALLOC_W | Lane instruction is speculative |
| alloc_br_i | input | ALLOC_W x BR_W | Branch identifier the lane depends on |
| alloc_stall_o | output | 1 | Allocation refused this cycle |
| alloc_tag_o | output | ALLOC_W x IDX_W | Slot index given to each lane |
| cmpl_valid_i | input | CMPL_W | Completion valid per port |
| cmpl_tag_i | input | CMPL_W x IDX_W | Slot index being completed |
| cmpl_data_i | input | CMPL_W x DATA_W | Result value |
| cmpl_exc_i | input | CMPL_W | Instruction faulted |
| br_valid_i | input | 1 | Branch resolution valid |
| br_mispred_i | input | 1 | Resolution is a mispredict |
| br_id_i | input | BR_W | Identifier of the resolving branch |
| br_entry_i | input | IDX_W | Slot index of the resolving branch |
| ret_valid_o | output | RET_W | Retire lane valid |
| ret_dest_o | output | RET_W x DEST_W | Destination register of retiring slot |
| ret_data_o | output | RET_W x DATA_W | Result of retiring slot |
| exc_valid_o | output | 1 | Precise fault request |
| exc_tag_o | output | IDX_W | Slot index of the faulting instruction |

## Verification
The bench sends completions in reverse order, so a queue that retired any complete slot instead of stopping at the oldest incomplete one would leak results early. It fills the queue to DEPTH and then asks for one and for two slots while one slot is free. A design that confused full with empty, or compared against the wrong free count, would overwrite live slots or refuse a legal request. After a mispredict, it completes a dropped slot and checks that the next index reuses the dropped position; a design that only marked squashed slots would retire them or hand out the wrong index. For a fault with three younger slots, it counts exactly three stalled cycles. It also checks that a faulting slot in lane 1 blocks only itself. A design that drained everything at once, retired the done younger slots, or let the fault pass through lane 1 would fail these checks.

// File: rtl/retire_queue_pkg.sv
package retire_queue_pkg;
  typedef enum logic {
    RQ_RUN   = 1'b0,
    RQ_DRAIN = 1'b1
  } rq_mode_e;
endpackage

// File: rtl/rq_alloc_ctl.sv
module rq_alloc_ctl #(
  parameter int ALLOC_W = 2,
  parameter int IDX_W   = 3,
  parameter int PTR_W   = 4
) (
  input  logic [ALLOC_W-1:0]            req_i,
  input  logic                          block_i,
  input  logic [PTR_W-1:0]              free_i,
  input  logic [IDX_W-1:0]              tail_idx_i,
  output logic                          stall_o,
  output logic [ALLOC_W-1:0]            we_o,
  output logic [ALLOC_W-1:0][IDX_W-1:0] tag_o,
  output logic [PTR_W-1:0]              n_alloc_o
);
  localparam int CNT_W = $clog2(ALLOC_W + 1);

  logic [ALLOC_W:0][CNT_W-1:0] rank;

  always_comb begin
    rank[0] = '0;
    for (int k = 0; k < ALLOC_W; k++) rank[k+1] = rank[k] + CNT_W'(req_i[k]);
  end

  for (genvar k = 0; k < ALLOC_W; k++) begin : g_tag
    assign tag_o[k] = tail_idx_i + IDX_W'(rank[k]);
  end

  always_comb begin
    stall_o   = block_i | (PTR_W'(rank[ALLOC_W]) > free_i);
    we_o      = stall_o ? '0 : req_i;
    n_alloc_o = stall_o ? '0 : PTR_W'(rank[ALLOC_W]);
  end
endmodule

// File: rtl/rq_retire_sel.sv
module rq_retire_sel #(
  parameter int DEPTH = 8,
  parameter int RET_W = 2,
  parameter int IDX_W = 3,
  parameter int PTR_W = 4
) (
  input  logic                        run_i,
  input  logic [IDX_W-1:0]            head_idx_i,
  input  logic [PTR_W-1:0]            occ_i,
  input  logic [DEPTH-1:0]            done_i,
  input  logic [DEPTH-1:0]            exc_i,
  input  logic [DEPTH-1:0]            spec_i,
  output logic [RET_W-1:0]            ret_o,
  output logic [RET_W-1:0][IDX_W-1:0] lane_idx_o,
  output logic                        exc_fire_o,
  output logic [PTR_W-1:0]            n_pop_o
);
  logic             ok;
  logic [PTR_W-1:0] n_ret;
  logic [PTR_W-1:0] drop;

  always_comb begin
    ok    = run_i;
    n_ret = '0;
    for (int k = 0; k < RET_W; k++) begin
      lane_idx_o[k] = head_idx_i + IDX_W'(k);
      ok = ok & (PTR_W'(k) < occ_i) & done_i[lane_idx_o[k]]
              & ~spec_i[lane_idx_o[k]] & ~exc_i[lane_idx_o[k]];
      ret_o[k] = ok;
      n_ret    = n_ret + PTR_W'(ok);
    end
    exc_fire_o = run_i & (occ_i != '0) & done_i[head_idx_i]
               & exc_i[head_idx_i] & ~spec_i[head_idx_i];
    if (!run_i)          drop = (occ_i < PTR_W'(RET_W)) ? occ_i : PTR_W'(RET_W);
    else if (exc_fire_o) drop = PTR_W'(1);
    else                 drop = '0;
    n_pop_o = n_ret + drop;
  end
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import retire_queue_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 32,
  parameter int DEST_W  = 5,
  parameter int BR_W    = 2,
  parameter int ALLOC_W = 2,
  parameter int CMPL_W  = 2,
  parameter int RET_W   = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ALLOC_W-1:0]             alloc_req_i,
  input  logic [ALLOC_W-1:0][DEST_W-1:0] alloc_dest_i,
  input  logic [ALLOC_W-1:0]             alloc_spec_i,
  input  logic [ALLOC_W-1:0][BR_W-1:0]   alloc_br_i,
  output logic                           alloc_stall_o,
  output logic [ALLOC_W-1:0][IDX_W-1:0]  alloc_tag_o,
  input  logic [CMPL_W-1:0]              cmpl_valid_i,
  input  logic [CMPL_W-1:0][IDX_W-1:0]   cmpl_tag_i,
  input  logic [CMPL_W-1:0][DATA_W-1:0]  cmpl_data_i,
  input  logic [CMPL_W-1:0]              cmpl_exc_i,
  input  logic                           br_valid_i,
  input  logic                           br_mispred_i,
  input  logic [BR_W-1:0]                br_id_i,
  input  logic [IDX_W-1:0]               br_entry_i,
  output logic [RET_W-1:0]               ret_valid_o,
  output logic [RET_W-1:0][DEST_W-1:0]   ret_dest_o,
  output logic [RET_W-1:0][DATA_W-1:0]   ret_data_o,
  output logic                           exc_valid_o,
  output logic [IDX_W-1:0]               exc_tag_o
);
  logic [PTR_W-1:0] head_q, tail_q, head_d, tail_d;
  rq_mode_e         mode_q, mode_d;

  logic [DEPTH-1:0]  done_v, exc_v, spec_v;
  logic [DEST_W-1:0] dest_v [DEPTH];
  logic [DATA_W-1:0] data_v [DEPTH];

  logic [PTR_W-1:0] occ, free_cnt, n_alloc, n_pop;
  logic [IDX_W-1:0] head_idx, br_off;
  logic             run, exc_fire, br_cut, block;
  logic [ALLOC_W-1:0]            alloc_we;
  logic [ALLOC_W-1:0][IDX_W-1:0] alloc_tag;
  logic [RET_W-1:0][IDX_W-1:0]   lane_idx;

  assign occ      = tail_q - head_q;
  assign free_cnt = PTR_W'(DEPTH) - occ;
  assign head_idx = head_q[IDX_W-1:0];
  assign run      = (mode_q == RQ_RUN);
  assign br_off   = br_entry_i - head_idx;
  assign br_cut   = br_valid_i & br_mispred_i & run & ~exc_fire & (PTR_W'(br_off) < occ);
  assign block    = ~run | exc_fire | br_cut;

  rq_alloc_ctl #(.ALLOC_W(ALLOC_W), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_alloc (
    .req_i      (alloc_req_i),
    .block_i    (block),
    .free_i     (free_cnt),
    .tail_idx_i (tail_q[IDX_W-1:0]),
    .stall_o    (alloc_stall_o),
    .we_o       (alloc_we),
    .tag_o      (alloc_tag),
    .n_alloc_o  (n_alloc)
  );
  assign alloc_tag_o = alloc_tag;

  rq_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_ret (
    .run_i      (run),
    .head_idx_i (head_idx),
    .occ_i      (occ),
    .done_i     (done_v),
    .exc_i      (exc_v),
    .spec_i     (spec_v),
    .ret_o      (ret_valid_o),
    .lane_idx_o (lane_idx),
    .exc_fire_o (exc_fire),
    .n_pop_o    (n_pop)
  );

  for (genvar k = 0; k < RET_W; k++) begin : g_rlane
    assign ret_dest_o[k] = dest_v[lane_idx[k]];
    assign ret_data_o[k] = data_v[lane_idx[k]];
  end

  assign exc_valid_o = exc_fire;
  assign exc_tag_o   = head_idx;

  always_comb begin
    head_d = head_q + n_pop;
    tail_d = br_cut ? head_q + PTR_W'(br_off) + PTR_W'(1) : tail_q + n_alloc;
    if (!run || exc_fire) mode_d = (head_d != tail_d) ? RQ_DRAIN : RQ_RUN;
    else                  mode_d = RQ_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      mode_q <= RQ_RUN;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      mode_q <= mode_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              done_r, exc_r, spec_r;
    logic [BR_W-1:0]   br_r;
    logic [DEST_W-1:0] dest_r;
    logic [DATA_W-1:0] data_r;
    logic              a_hit, a_spec, c_hit, c_exc, live, clr;
    logic [BR_W-1:0]   a_br;
    logic [DEST_W-1:0] a_dest;
    logic [DATA_W-1:0] c_data;
    logic [IDX_W-1:0]  rel;

    always_comb begin
      rel    = IDX_W'(i) - head_idx;
      live   = PTR_W'(rel) < occ;
      a_hit  = 1'b0;
      a_spec = 1'b0;
      a_br   = '0;
      a_dest = '0;
      for (int k = 0; k < ALLOC_W; k++) begin
        if (alloc_we[k] && alloc_tag[k] == IDX_W'(i)) begin
          a_hit  = 1'b1;
          a_spec = alloc_spec_i[k];
          a_br   = alloc_br_i[k];
          a_dest = alloc_dest_i[k];
        end
      end
      c_hit  = 1'b0;
      c_exc  = 1'b0;
      c_data = '0;
      for (int c = 0; c < CMPL_W; c++) begin
        if (run && live && cmpl_valid_i[c] && cmpl_tag_i[c] == IDX_W'(i)) begin
          c_hit  = 1'b1;
          c_exc  = cmpl_exc_i[c];
          c_data = cmpl_data_i[c];
        end
      end
      clr = br_valid_i & ~br_mispred_i & run & spec_r & (br_r == br_id_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_r <= 1'b0;
        exc_r  <= 1'b0;
        spec_r <= 1'b0;
        br_r   <= '0;
        dest_r <= '0;
        data_r <= '0;
      end else if (a_hit) begin
        done_r <= 1'b0;
        exc_r  <= 1'b0;
        spec_r <= a_spec;
        br_r   <= a_br;
        dest_r <= a_dest;
      end else begin
        if (c_hit) begin
          done_r <= 1'b1;
          exc_r  <= c_exc;
          data_r <= c_data;
        end
        if (clr) spec_r <= 1'b0;
      end
    end

    assign done_v[i] = done_r;
    assign exc_v[i]  = exc_r;
    assign spec_v[i] = spec_r;
    assign dest_v[i] = dest_r;
    assign data_v[i] = data_r;
  end
endmodule

// File: rtl/retire_queue_chk.sv
module retire_queue_chk #(
  parameter int DEPTH = 8,
  parameter int RET_W = 2,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RET_W-1:0] ret_valid_i,
  input logic             exc_valid_i,
  input logic             alloc_stall_i,
  input logic [PTR_W-1:0] occ_i
);
  AST_EXC_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> !exc_valid_i);                                   // R8
  AST_EXC_NO_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> (ret_valid_i == '0));                            // R8
  AST_EXC_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> alloc_stall_i);                                  // R8
  AST_RET_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i & (ret_valid_i + 1'b1)) == '0);                     // R5
  AST_RET_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PTR_W'($countones(ret_valid_i)) <= occ_i);                       // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= PTR_W'(DEPTH));                                         // R10
  AST_STALL_NO_GROWTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_stall_i |=> occ_i <= $past(occ_i));                        // R3
endmodule

bind retire_queue retire_queue_chk #(.DEPTH(DEPTH), .RET_W(RET_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ret_valid_i   (ret_valid_o),
  .exc_valid_i   (exc_valid_o),
  .alloc_stall_i (alloc_stall_o),
  .occ_i         (occ)
);

// File: tb/tb_retire_queue.sv
module tb_retire_queue;
  localparam int DEPTH = 8, DATA_W = 32, DEST_W = 5, BR_W = 2;
  localparam int ALLOC_W = 2, CMPL_W = 2, RET_W = 2, IDX_W = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [ALLOC_W-1:0]             alloc_req_i;
  logic [ALLOC_W-1:0][DEST_W-1:0] alloc_dest_i;
  logic [ALLOC_W-1:0]             alloc_spec_i;
  logic [ALLOC_W-1:0][BR_W-1:0]   alloc_br_i;
  logic                           alloc_stall_o;
  logic [ALLOC_W-1:0][IDX_W-1:0]  alloc_tag_o;
  logic [CMPL_W-1:0]              cmpl_valid_i;
  logic [CMPL_W-1:0][IDX_W-1:0]   cmpl_tag_i;
  logic [CMPL_W-1:0][DATA_W-1:0]  cmpl_data_i;
  logic [CMPL_W-1:0]              cmpl_exc_i;
  logic                           br_valid_i, br_mispred_i;
  logic [BR_W-1:0]                br_id_i;
  logic [IDX_W-1:0]               br_entry_i;
  logic [RET_W-1:0]               ret_valid_o;
  logic [RET_W-1:0][DEST_W-1:0]   ret_dest_o;
  logic [RET_W-1:0][DATA_W-1:0]   ret_data_o;
  logic                           exc_valid_o;
  logic [IDX_W-1:0]               exc_tag_o;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  retire_queue dut (.*);

  task automatic chk(input string r, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic idle();
    alloc_req_i = '0; alloc_dest_i = '0; alloc_spec_i = '0; alloc_br_i = '0;
    cmpl_valid_i = '0; cmpl_tag_i = '0; cmpl_data_i = '0; cmpl_exc_i = '0;
    br_valid_i = 1'b0; br_mispred_i = 1'b0; br_id_i = '0; br_entry_i = '0;
  endtask

  task automatic alloc(input int n, input bit sp, input int br, input int d0, input int d1,
                       input int t0, input string r);
    alloc_req_i     = (n == 2) ? 2'b11 : 2'b01;
    alloc_spec_i    = {sp, sp};
    alloc_br_i[0]   = BR_W'(br);
    alloc_br_i[1]   = BR_W'(br);
    alloc_dest_i[0] = DEST_W'(d0);
    alloc_dest_i[1] = DEST_W'(d1);
    #1;
    chk({r, " stall"}, alloc_stall_o, 0);
    chk({r, " tag0"}, alloc_tag_o[0], t0 % DEPTH);
    if (n == 2) chk({r, " tag1"}, alloc_tag_o[1], (t0 + 1) % DEPTH);
    @(negedge clk_i);
    idle();
  endtask

  task automatic cmpl(input int t0, input int d0, input bit e0,
                      input int t1, input int d1, input bit e1);
    cmpl_valid_i[0] = 1'b1; cmpl_tag_i[0] = IDX_W'(t0);
    cmpl_data_i[0] = DATA_W'(d0); cmpl_exc_i[0] = e0;
    if (t1 >= 0) begin
      cmpl_valid_i[1] = 1'b1; cmpl_tag_i[1] = IDX_W'(t1);
      cmpl_data_i[1] = DATA_W'(d1); cmpl_exc_i[1] = e1;
    end
    @(negedge clk_i);
    idle();
  endtask

  task automatic expect_ret(input logic [1:0] v, input int ds0, input int dt0,
                            input int ds1, input int dt1, input string r);
    #1;
    chk({r, " ret_valid"}, ret_valid_o, v);
    if (v[0]) begin
      chk({r, " dest0"}, ret_dest_o[0], ds0);
      chk({r, " data0"}, ret_data_o[0], dt0);
    end
    if (v[1]) begin
      chk({r, " dest1"}, ret_dest_o[1], ds1);
      chk({r, " data1"}, ret_data_o[1], dt1);
    end
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ret idle", ret_valid_o, 0);
    chk("R1 no exc", exc_valid_o, 0);
    chk("R1 no stall", alloc_stall_o, 0);
    @(negedge clk_i);
    alloc(2, 0, 0, 1, 2, 0, "R1 R2 first tags");
  endtask

  task automatic t_out_of_order();
    cmpl(1, 'h11, 0, -1, 0, 0);
    expect_ret(2'b00, 0, 0, 0, 0, "R4 head not done");
    cmpl(0, 'h10, 0, -1, 0, 0);
    expect_ret(2'b11, 1, 'h10, 2, 'h11, "R5 two in order");
    expect_ret(2'b00, 0, 0, 0, 0, "R4 empty");
  endtask

  task automatic t_width();
    alloc(2, 0, 0, 3, 4, 2, "R2 pair");
    alloc(1, 0, 0, 5, 0, 4, "R2 single");
    cmpl(4, 'h44, 0, -1, 0, 0);
    cmpl(2, 'h22, 0, 3, 'h33, 0);
    expect_ret(2'b11, 3, 'h22, 4, 'h33, "R5 limit two");
    expect_ret(2'b01, 5, 'h44, 0, 0, "R5 remaining one");
    expect_ret(2'b00, 0, 0, 0, 0, "R5 drained");
  endtask

  task automatic t_spec();
    alloc(1, 0, 0, 7, 0, 5, "R6 branch slot");
    alloc(2, 1, 1, 8, 9, 6, "R6 spec slots");
    cmpl(6, 'h66, 0, 7, 'h77, 0);
    cmpl(5, 'h55, 0, -1, 0, 0);
    expect_ret(2'b01, 7, 'h55, 0, 0, "R6 nonspec only");
    expect_ret(2'b00, 0, 0, 0, 0, "R6 spec held");
    br_valid_i = 1'b1; br_id_i = 2'd2;
    @(negedge clk_i);
    idle();
    expect_ret(2'b00, 0, 0, 0, 0, "R6 other id ignored");
    br_valid_i = 1'b1; br_id_i = 2'd1;
    @(negedge clk_i);
    idle();
    expect_ret(2'b11, 8, 'h66, 9, 'h77, "R6 confirmed");
  endtask

  task automatic t_full();
    for (int c = 0; c < 4; c++) alloc(2, 0, 0, 10 + 2 * c, 11 + 2 * c, 2 * c, "R10 fill");
    alloc_req_i = 2'b01;
    #1;
    chk("R10 full refuses one", alloc_stall_o, 1);
    idle();
    @(negedge clk_i);
    cmpl(0, 'hA0, 0, -1, 0, 0);
    expect_ret(2'b01, 10, 'hA0, 0, 0, "R10 retire from full");
    alloc_req_i = 2'b11;
    #1;
    chk("R3 two asked one free", alloc_stall_o, 1);
    idle();
    @(negedge clk_i);
    alloc(1, 0, 0, 20, 0, 0, "R3 R10 one fits wraps");
    cmpl(7, 'hB7, 0, 0, 'hB0, 0);
    cmpl(5, 'hB5, 0, 6, 'hB6, 0);
    cmpl(3, 'hB3, 0, 4, 'hB4, 0);
    cmpl(1, 'hB1, 0, 2, 'hB2, 0);
    expect_ret(2'b11, 11, 'hB1, 12, 'hB2, "R10 wrap order a");
    expect_ret(2'b11, 13, 'hB3, 14, 'hB4, "R10 wrap order b");
    expect_ret(2'b11, 15, 'hB5, 16, 'hB6, "R10 wrap order c");
    expect_ret(2'b11, 17, 'hB7, 20, 'hB0, "R10 wrap order d");
    expect_ret(2'b00, 0, 0, 0, 0, "R10 empty");
  endtask

  task automatic t_mispred();
    alloc(1, 0, 0, 21, 0, 1, "R7 branch slot");
    alloc(2, 1, 2, 22, 23, 2, "R7 wrong path");
    alloc(1, 1, 2, 24, 0, 4, "R7 wrong path");
    br_valid_i = 1'b1; br_mispred_i = 1'b1; br_id_i = 2'd2; br_entry_i = 3'd1;
    alloc_req_i = 2'b01;
    #1;
    chk("R7 stall on mispredict", alloc_stall_o, 1);
    @(negedge clk_i);
    idle();
    alloc(1, 0, 0, 25, 0, 2, "R7 tail after branch");
    cmpl(3, 'hDD, 0, -1, 0, 0);
    cmpl(2, 'hC2, 0, 1, 'hC1, 0);
    expect_ret(2'b11, 21, 'hC1, 25, 'hC2, "R7 survivors");
    expect_ret(2'b00, 0, 0, 0, 0, "R7 squashed never retire");
    alloc(1, 0, 0, 26, 0, 3, "R7 reuse dropped slot");
    expect_ret(2'b00, 0, 0, 0, 0, "R4 fresh slot not done");
    cmpl(3, 'hE3, 0, -1, 0, 0);
    expect_ret(2'b01, 26, 'hE3, 0, 0, "R4 fresh slot retires");
  endtask

  task automatic t_exc();
    int n;
    alloc(2, 0, 0, 27, 28, 4, "R8 fill");
    alloc(2, 0, 0, 29, 30, 6, "R8 fill");
    alloc(1, 0, 0, 31, 0, 0, "R8 fill");
    cmpl(5, 'h55, 1, 6, 'h66, 0);
    cmpl(7, 'h77, 0, 0, 'h70, 0);
    cmpl(4, 'h44, 0, -1, 0, 0);
    #1;
    chk("R11 lane0 retires", ret_valid_o, 2'b01);
    chk("R11 lane0 dest", ret_dest_o[0], 27);
    chk("R11 no exc yet", exc_valid_o, 0);
    @(negedge clk_i);
    n = 0;
    for (int i = 0; i < 6; i++) begin
      #1;
      if (i == 0) begin
        chk("R8 exc raised", exc_valid_o, 1);
        chk("R8 exc tag", exc_tag_o, 5);
      end
      if (i == 1) chk("R8 exc one cycle", exc_valid_o, 0);
      if (alloc_stall_o) begin
        n++;
        chk("R9 drain no retire", ret_valid_o, 0);
      end
      @(negedge clk_i);
    end
    chk("R9 drain cycles", n, 3);
    alloc(1, 0, 0, 5, 0, 1, "R9 resume after drain");
    cmpl(1, 'hF1, 0, -1, 0, 0);
    expect_ret(2'b01, 5, 'hF1, 0, 0, "R9 resumed slot retires");
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_out_of_order();
    t_width();
    t_spec();
    t_full();
    t_mispred();
    t_exc();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule